// File: doc/BRIEF.md
# Link Park Controller for Processor Low-Power States

This block is the processor-side tracker of the system-bus link during the Halt and Stop Grant low-power states. Once the core's own issue logic has sent a low-power special cycle, it raises a park request. The host then drops its link-enable input, and the controller walks the link from linked, through a short drop-pending step, into a parked state. In the parked state the core-ready output is withdrawn and a slow-clock enable is raised. That enable tells the downstream clock divider to run the core at a reduced rate.

A wake event cancels a drop that is still pending. A wake event or the host raising its link-enable again leaves the parked state. A wake goes through a wake-pending state, which asks the core to issue a Connect special cycle. A host reconnect goes through a host-pending state. In both cases the slow-clock enable falls first, and core-ready returns one clock later, so the full-rate clock is already running when the link is declared ready.

The divide ratio used while parked comes from a small register that may be written at any time. Its value is copied to the divider output only when the controller enters the parked state.

Top module: `link_park_fsm`

## Requirements
- R1: While reset is asserted and after its release, with no activity, the block is in state code 0 (linked). In that state `core_ready_o`=1, `slow_en_o`=0, `link_cyc_req_o`=0, and `slow_div_o` equals the parameter RESET_DIV.
- R2: From state 0, the state becomes 1 (drop pending) one clock after an edge at which `park_req_i`=1 and `host_link_i`=0. Without `park_req_i`, a low `host_link_i` leaves the state at 0. With `host_link_i` high, `park_req_i` also leaves the state at 0.
- R3: In state 1, an edge with `wake_i`=1 or `host_link_i`=1 returns the state to 0 (the drop is cancelled). `core_ready_o` stays 1 during state 1.
- R4: In state 1, an edge with neither `wake_i` nor `host_link_i` moves the state to 2 (parked). In state 2, `core_ready_o`=0 and `slow_en_o`=1.
- R5: In state 2, an edge with `wake_i`=1 moves the state to 3 (wake pending), even if `host_link_i` is also 1. `link_cyc_req_o` is 1 exactly while the state is 3.
- R6: In state 2, an edge with `host_link_i`=1 and `wake_i`=0 moves the state to 4 (host pending), and `link_cyc_req_o` stays 0.
- R7: States 3 and 4 last one clock each, with `slow_en_o`=0 and `core_ready_o`=0, and then return to state 0. `core_ready_o` therefore rises one clock after `slow_en_o` falls.
- R8: A cycle with `div_wr_i`=1 loads `div_data_i` into the divisor register. `slow_div_o` changes only on the edge that enters state 2, where it takes the register value held before that edge. A write made on that same edge applies from the next entry onward.
- R9: In state 2, an edge with neither `wake_i` nor `host_link_i` keeps the state at 2, whatever the value of `park_req_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_link_i | input | 1 | Link enable from the host; low requests or holds the disconnect |
| wake_i | input | 1 | Core wake event (interrupt or stop-clock release) |
| park_req_i | input | 1 | A Halt or Stop Grant special cycle has been issued |
| div_wr_i | input | 1 | Write strobe for the divisor register |
| div_data_i | input | DIV_W | Divisor value to write |
| core_ready_o | output | 1 | Processor-ready toward the host |
| slow_en_o | output | 1 | Selects the slowed internal clock |
| slow_div_o | output | DIV_W | Divisor applied while parked |
| link_cyc_req_o | output | 1 | Request to issue a Connect special cycle |
| state_o | output | 3 | Current state code (0 linked, 1 drop pending, 2 parked, 3 wake pending, 4 host pending) |

## Verification
The main flow is driven through four patterns, each of which separates a different pair of transitions:
- A host-driven round trip shows the state-4 path and shows that no Connect request is raised on it.
- A wake with the host also reconnecting confirms that wake takes priority.
- Cancels by wake and by host, made during drop pending, show that the state returns to 0 without ever parking.
- Divisor writes made while linked, while parked and on the entry edge itself show that only the value held before entry is captured.

A long stretch of pseudo-random input levels then checks every transition against the behavioural model on every clock.

// File: rtl/link_park_pkg.sv
package link_park_pkg;

  typedef enum logic [2:0] {
    LP_LINKED    = 3'd0,
    LP_DROP_PEND = 3'd1,
    LP_PARKED    = 3'd2,
    LP_WAKE_PEND = 3'd3,
    LP_HOST_PEND = 3'd4
  } lp_state_e;

  // Next-state rule; wake outranks the host on every decision.
  function automatic lp_state_e lp_next(input lp_state_e cur, input logic park_req,
                                        input logic host_up, input logic wake);
    lp_state_e nxt;
    nxt = cur;
    case (cur)
      LP_LINKED:    if (park_req && !host_up) nxt = LP_DROP_PEND;
      LP_DROP_PEND: nxt = (wake || host_up) ? LP_LINKED : LP_PARKED;
      LP_PARKED: begin
        if (wake)         nxt = LP_WAKE_PEND;
        else if (host_up) nxt = LP_HOST_PEND;
      end
      LP_WAKE_PEND: nxt = LP_LINKED;
      LP_HOST_PEND: nxt = LP_LINKED;
      default:      nxt = LP_LINKED;
    endcase
    return nxt;
  endfunction

  function automatic logic lp_is_ready(input lp_state_e s);
    return (s == LP_LINKED) || (s == LP_DROP_PEND);
  endfunction

endpackage

// File: rtl/lp_state_ctl.sv
module lp_state_ctl
  import link_park_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      host_link_i,
  input  logic      wake_i,
  input  logic      park_req_i,
  output lp_state_e state_o,
  output logic      enter_park_o
);

  lp_state_e state_q;
  lp_state_e state_d;

  always_comb begin
    state_d      = lp_next(state_q, park_req_i, host_link_i, wake_i);
    enter_park_o = (state_q == LP_DROP_PEND) && (state_d == LP_PARKED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LP_LINKED;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/lp_div_hold.sv
module lp_div_hold #(
  parameter int DIV_W     = 3,
  parameter int RESET_DIV = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [DIV_W-1:0] data_i,
  input  logic             capture_i,
  output logic [DIV_W-1:0] active_o
);

  localparam logic [DIV_W-1:0] RST_VAL = DIV_W'(RESET_DIV);

  logic [DIV_W-1:0] prog_q;
  logic [DIV_W-1:0] active_q;

  // Programmed value: writable any cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    prog_q <= RST_VAL;
    else if (wr_i) prog_q <= data_i;
  end

  // Applied value: copied only on the edge entering the parked state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         active_q <= RST_VAL;
    else if (capture_i) active_q <= prog_q;
  end

  assign active_o = active_q;

endmodule

// File: rtl/link_park_fsm.sv
module link_park_fsm
  import link_park_pkg::*;
#(
  parameter int DIV_W     = 3,
  parameter int RESET_DIV = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_link_i,
  input  logic             wake_i,
  input  logic             park_req_i,
  input  logic             div_wr_i,
  input  logic [DIV_W-1:0] div_data_i,
  output logic             core_ready_o,
  output logic             slow_en_o,
  output logic [DIV_W-1:0] slow_div_o,
  output logic             link_cyc_req_o,
  output logic [2:0]       state_o
);

  lp_state_e cur_state;
  logic      enter_park;

  lp_state_ctl u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_link_i  (host_link_i),
    .wake_i       (wake_i),
    .park_req_i   (park_req_i),
    .state_o      (cur_state),
    .enter_park_o (enter_park)
  );

  lp_div_hold #(.DIV_W(DIV_W), .RESET_DIV(RESET_DIV)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (div_wr_i),
    .data_i    (div_data_i),
    .capture_i (enter_park),
    .active_o  (slow_div_o)
  );

  // Moore outputs: the slow clock is enabled only in the parked state.
  // Ready is withdrawn from the parked state through both pending states.
  always_comb begin
    core_ready_o   = lp_is_ready(cur_state);
    slow_en_o      = (cur_state == LP_PARKED);
    link_cyc_req_o = (cur_state == LP_WAKE_PEND);
    state_o        = cur_state;
  end

endmodule

// File: rtl/link_park_chk.sv
module link_park_chk #(
  parameter int DIV_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_link_i,
  input logic             wake_i,
  input logic             park_req_i,
  input logic             core_ready_o,
  input logic             slow_en_o,
  input logic [DIV_W-1:0] slow_div_o,
  input logic             link_cyc_req_o,
  input logic [2:0]       state_o
);

  // R2: drop pending is entered only after a park request with the host link low
  a_r2_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1 && $past(state_o) == 3'd0) |-> ($past(park_req_i) && !$past(host_link_i)));

  // R3: ready stays up while a drop is only pending
  a_r3_ready_in_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1) |-> core_ready_o);

  // R4: parked means not ready and slowed
  a_r4_parked_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd2) |-> (!core_ready_o && slow_en_o));

  // R5: the Connect request follows a wake seen while parked
  a_r5_cyc_from_wake: assert property (@(posedge clk) disable iff (!rst_n)
    link_cyc_req_o |-> ($past(state_o) == 3'd2 && $past(wake_i)));

  // R7: the slow clock is removed before ready returns
  a_r7_slow_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slow_en_o) |-> !core_ready_o);

  // R7: ready follows one clock after the slow clock is removed
  a_r7_ready_next: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slow_en_o) |=> core_ready_o);

  // R8: the applied divisor moves only on entry to the parked state
  a_r8_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(state_o == 3'd2 && $past(state_o) != 3'd2) |-> $stable(slow_div_o));

endmodule

bind link_park_fsm link_park_chk #(.DIV_W(DIV_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .host_link_i    (host_link_i),
  .wake_i         (wake_i),
  .park_req_i     (park_req_i),
  .core_ready_o   (core_ready_o),
  .slow_en_o      (slow_en_o),
  .slow_div_o     (slow_div_o),
  .link_cyc_req_o (link_cyc_req_o),
  .state_o        (state_o)
);

// File: tb/link_park_fsm_tb.sv
module link_park_fsm_tb;

  localparam int DIV_W = 3;
  localparam int RESET_DIV = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_link_i = 1'b1;
  logic wake_i = 1'b0;
  logic park_req_i = 1'b0;
  logic div_wr_i = 1'b0;
  logic [DIV_W-1:0] div_data_i = '0;
  logic core_ready_o, slow_en_o, link_cyc_req_o;
  logic [DIV_W-1:0] slow_div_o;
  logic [2:0] state_o;

  link_park_fsm #(.DIV_W(DIV_W), .RESET_DIV(RESET_DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_link_i(host_link_i), .wake_i(wake_i),
    .park_req_i(park_req_i), .div_wr_i(div_wr_i), .div_data_i(div_data_i),
    .core_ready_o(core_ready_o), .slow_en_o(slow_en_o), .slow_div_o(slow_div_o),
    .link_cyc_req_o(link_cyc_req_o), .state_o(state_o)
  );

  always #5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  string phase = "R1";
  bit done = 1'b0;

  // Behavioural reference: named states as integers, divisor as two integers.
  int m_st = 0;
  int m_prog = RESET_DIV;
  int m_appl = RESET_DIV;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_prog = RESET_DIV; m_appl = RESET_DIV;
    end else begin
      int nx;
      nx = m_st;
      if (m_st == 0) begin
        if (park_req_i === 1'b1 && host_link_i === 1'b0) nx = 1;
      end else if (m_st == 1) begin
        if (wake_i || host_link_i) nx = 0; else nx = 2;
      end else if (m_st == 2) begin
        if (wake_i) nx = 3; else if (host_link_i) nx = 4;
      end else begin
        nx = 0;
      end
      if (m_st == 1 && nx == 2) m_appl = m_prog;
      if (div_wr_i) m_prog = int'(div_data_i);
      m_st = nx;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      logic e_rdy, e_slow, e_cyc;
      e_rdy  = (m_st <= 1);
      e_slow = (m_st == 2);
      e_cyc  = (m_st == 3);
      compared++;
      if (state_o !== 3'(m_st) || core_ready_o !== e_rdy || slow_en_o !== e_slow ||
          link_cyc_req_o !== e_cyc || slow_div_o !== DIV_W'(m_appl)) begin
        mismatched++;
        $display("FAIL %s t=%0t: got st=%0d rdy=%b slow=%b cyc=%b div=%0d, expected st=%0d rdy=%b slow=%b cyc=%b div=%0d",
                 phase, $time, state_o, core_ready_o, slow_en_o, link_cyc_req_o, slow_div_o,
                 m_st, e_rdy, e_slow, e_cyc, m_appl);
      end
    end
  end

  task automatic step(input bit park, input bit host, input bit wk,
                      input bit wr, input int data, input string tag);
    @(negedge clk);
    #1;
    phase = tag;
    park_req_i = park; host_link_i = host; wake_i = wk;
    div_wr_i = wr; div_data_i = DIV_W'(data);
  endtask

  initial begin
    phase = "R1";
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    step(0, 1, 0, 0, 0, "R1");
    step(0, 1, 0, 0, 0, "R1");
    // R2: each input alone does not start a drop
    repeat (3) step(0, 0, 0, 0, 0, "R2");
    repeat (2) step(1, 1, 0, 1, 5, "R2_R8");
    step(1, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 0, 0, "R4");
    repeat (3) step(1, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 1, 6, "R8");
    step(0, 0, 0, 0, 0, "R9");
    // R6: host reconnect path
    step(0, 1, 0, 0, 0, "R6");
    step(0, 1, 0, 0, 0, "R7");
    step(0, 1, 0, 0, 0, "R7");
    // R5: wake and host together, wake wins
    step(1, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 0, 0, "R4");
    step(1, 0, 0, 0, 0, "R9");
    step(0, 1, 1, 0, 0, "R5");
    step(0, 1, 0, 0, 0, "R7");
    step(0, 1, 0, 0, 0, "R7");
    // R3: cancel by wake, then by host
    step(1, 0, 0, 0, 0, "R2");
    step(0, 0, 1, 0, 0, "R3");
    step(0, 0, 0, 0, 0, "R3");
    step(1, 0, 0, 0, 0, "R2");
    step(0, 1, 0, 0, 0, "R3");
    step(0, 1, 0, 0, 0, "R3");
    // R8: write on the entry edge applies only from the next entry
    step(1, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 1, 2, "R8");
    step(0, 0, 0, 0, 0, "R8");
    step(0, 0, 1, 0, 0, "R5");
    step(0, 0, 0, 0, 0, "R7");
    step(1, 0, 0, 0, 0, "R8");
    step(1, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, "R8");
    step(0, 1, 0, 0, 0, "R6");
    step(0, 1, 0, 0, 0, "R7");
    // Mixed pseudo-random levels
    for (int i = 0; i < 2000; i++) begin
      int r;
      r = int'($urandom);
      step(r[0] | r[1], r[2] & r[3], r[4] & r[5] & r[6], r[7], r[10:8], "R2-mix");
    end
    step(0, 1, 0, 0, 0, "R7");
    @(negedge clk);
    #2 done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule